// File: doc/BRIEF.md
# Instruction Stream Binding Buffer

This block turns a short, fixed fuzz test vector into an endless instruction stream that two fetch clients share. One client is a reference model and the other is the core under test. Each client presents fetch addresses and receives 32-bit instruction words. The buffer does not map a word to an address by offset. It binds words in the order that new addresses first appear. The first fetch of an unseen address takes the next unused word of the vector and records the pair. From then on, every fetch of that address, from either client, returns the recorded word.

The two clients can follow different fetch orders and timings and still observe the same program. A load pulse installs a fresh vector and starts a new program. The bindings live in a small associative table. When the table is full, fetches of new addresses get a no-op word and a sticky flag is raised.

Top module: `istream_bind_buf`

## Requirements
- R1: After reset, both response valids are low, the overflow flag is low and both request readies are high.
- R2: The first fetch of a new address returns the next vector word in sequence. Word k occupies vector bits [32k+31:32k], so word 0 is the lowest 32 bits, and a fresh program starts at word 0.
- R3: A later fetch of an address that is already bound returns the bound word and does not consume a vector word.
- R4: After word 4 has been handed out, the next new address receives word 0 again.
- R5: An address bound through one port returns the same word when it is fetched through the other port.
- R6: When both ports fetch the same unbound address in the same cycle, one word is consumed, both ports receive it, and the next new address gets the word that follows.
- R7: When both ports fetch different unbound addresses in the same cycle, port 0 receives the earlier word and port 1 the one after it.
- R8: Every accepted request produces exactly one response in the following cycle, and a response appears only in that case.
- R9: Once 64 bindings exist, a fetch of an unbound address returns 32'h00000013, consumes no vector word and sets the overflow flag. The flag stays set until the next load. Bound addresses still return their words.
- R10: A load pulse deasserts both readies for that cycle, captures the new vector, removes all bindings, restarts allocation at word 0 and clears the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Pulse that installs a new vector and clears bindings |
| vector_i | input | 160 | Test vector, five 32-bit words, word 0 in the low bits |
| p0_req_valid | input | 1 | Port 0 fetch request |
| p0_req_ready | output | 1 | Port 0 can accept a request |
| p0_req_addr | input | 32 | Port 0 fetch address |
| p0_rsp_valid | output | 1 | Port 0 response present |
| p0_rsp_word | output | 32 | Port 0 instruction word |
| p1_req_valid | input | 1 | Port 1 fetch request |
| p1_req_ready | output | 1 | Port 1 can accept a request |
| p1_req_addr | input | 32 | Port 1 fetch address |
| p1_rsp_valid | output | 1 | Port 1 response present |
| p1_rsp_word | output | 32 | Port 1 instruction word |
| overflow_o | output | 1 | Sticky flag: a new address found the table full |

## Verification
The bench uses the default parameters: five vector words and a 64-slot table. Five words make the wrap back to word 0 appear after only a handful of new addresses. A 64-slot table can be filled with 63 single-port fetches, which sets up the one-slot-left case. Two different new addresses in that state split between a granted port 0 and an overflowing port 1. The filled table also allows a check that bound addresses still hit after the overflow.

// File: rtl/ibb_pkg.sv
// Shared definitions for the instruction stream binding buffer.
// Assumes: 32-bit instruction words, so the default fill word is a 32-bit no-op.
package ibb_pkg;
    localparam logic [31:0] IBB_NOP_WORD = 32'h0000_0013;

    // Where a port's response word comes from in the current cycle.
    typedef enum logic [2:0] {
        SRC_IDLE,     // no request accepted
        SRC_HIT,      // address already bound
        SRC_FRESH_A,  // bound now to the first free vector word
        SRC_FRESH_B,  // bound now to the second free vector word
        SRC_SHARED,   // same new address as port 0 this cycle
        SRC_FILL      // table full: fill word
    } ibb_src_e;
endpackage

// File: rtl/ibb_entry_alloc.sv
// Entry allocator: holds the captured test vector and the index of the next
// unused word. Offers the next two words in sequence and advances by 0, 1 or 2.
// Assumes: adv_i never exceeds 2; load_i has priority over advance.
module ibb_entry_alloc #(
    parameter int NUM_ENTRIES = 5,
    parameter int WORD_W      = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [NUM_ENTRIES*WORD_W-1:0] vector_i,
    input  logic [1:0]                    adv_i,
    output logic [WORD_W-1:0]             word_a_o,
    output logic [WORD_W-1:0]             word_b_o
);
    localparam int VEC_W = NUM_ENTRIES * WORD_W;
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    logic [VEC_W-1:0]  vec_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  idx_b;
    logic [IDX_W-1:0]  idx_c;
    logic [WORD_W-1:0] entry [NUM_ENTRIES];

    // Wrapping increment of an entry index.
    function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
        return (i == LAST_IDX) ? '0 : i + 1'b1;
    endfunction

    // Slice the captured vector into its words.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        assign entry[g] = vec_q[g*WORD_W +: WORD_W];
    end

    // Indices of the second word and of the word after it.
    always_comb begin
        idx_b = step_idx(idx_q);
        idx_c = step_idx(idx_b);
    end

    // Select the two candidate words for this cycle.
    always_comb begin
        word_a_o = '0;
        word_b_o = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (idx_q == IDX_W'(i)) word_a_o = entry[i];
            if (idx_b == IDX_W'(i)) word_b_o = entry[i];
        end
    end

    // Capture the vector on load.
    always_ff @(posedge clk) begin
        if (!rst_n)      vec_q <= '0;
        else if (load_i) vec_q <= vector_i;
    end

    // Restart on load, otherwise advance by the number of words consumed.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) idx_q <= '0;
        else begin
            case (adv_i)
                2'd1:    idx_q <= idx_b;
                2'd2:    idx_q <= idx_c;
                default: idx_q <= idx_q;
            endcase
        end
    end
endmodule

// File: rtl/ibb_bind_table.sv
// Binding table: a fully associative store of address/word pairs filled in
// order. It has two lookup ports and up to two writes per cycle. The second
// write lands in the slot after the first.
// Assumes: the caller never writes more pairs than free slots, never writes an
// address that is already bound, and asserts wr_b_en only together with wr_a_en.
module ibb_bind_table #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [ADDR_W-1:0] look0_addr_i,
    output logic              look0_hit_o,
    output logic [WORD_W-1:0] look0_word_o,
    input  logic [ADDR_W-1:0] look1_addr_i,
    output logic              look1_hit_o,
    output logic [WORD_W-1:0] look1_word_o,
    input  logic              wr_a_en_i,
    input  logic [ADDR_W-1:0] wr_a_addr_i,
    input  logic [WORD_W-1:0] wr_a_word_i,
    input  logic              wr_b_en_i,
    input  logic [ADDR_W-1:0] wr_b_addr_i,
    input  logic [WORD_W-1:0] wr_b_word_i,
    output logic [CNT_W-1:0]  used_o
);
    logic [CNT_W-1:0]  used_q;
    logic [CNT_W-1:0]  slot_a;
    logic [CNT_W-1:0]  slot_b;
    logic [DEPTH-1:0]  hit0_vec;
    logic [DEPTH-1:0]  hit1_vec;
    logic [WORD_W-1:0] chain0 [DEPTH+1];
    logic [WORD_W-1:0] chain1 [DEPTH+1];

    // Target slots for this cycle's writes.
    always_comb begin
        slot_a = used_q;
        slot_b = used_q + CNT_W'(wr_a_en_i);
    end

    // Occupancy count: cleared on clear, grows by the number of writes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) used_q <= '0;
        else                 used_q <= used_q + CNT_W'(wr_a_en_i) + CNT_W'(wr_b_en_i);
    end

    assign chain0[0] = '0;
    assign chain1[0] = '0;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [CNT_W-1:0] SLOT = CNT_W'(g);
        logic              vld_q;
        logic [ADDR_W-1:0] addr_q;
        logic [WORD_W-1:0] word_q;
        logic              take_a;
        logic              take_b;

        assign take_a = wr_a_en_i && (slot_a == SLOT);
        assign take_b = wr_b_en_i && (slot_b == SLOT);

        // Slot occupancy.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i)       vld_q <= 1'b0;
            else if (take_a || take_b) vld_q <= 1'b1;
        end

        // Slot contents, written once per program.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
                word_q <= '0;
            end else if (take_a) begin
                addr_q <= wr_a_addr_i;
                word_q <= wr_a_word_i;
            end else if (take_b) begin
                addr_q <= wr_b_addr_i;
                word_q <= wr_b_word_i;
            end
        end

        assign hit0_vec[g]  = vld_q && (addr_q == look0_addr_i);
        assign hit1_vec[g]  = vld_q && (addr_q == look1_addr_i);
        assign chain0[g+1]  = chain0[g] | (hit0_vec[g] ? word_q : '0);
        assign chain1[g+1]  = chain1[g] | (hit1_vec[g] ? word_q : '0);
    end

    assign look0_hit_o  = |hit0_vec;
    assign look1_hit_o  = |hit1_vec;
    assign look0_word_o = chain0[DEPTH];
    assign look1_word_o = chain1[DEPTH];
    assign used_o       = used_q;
endmodule

// File: rtl/ibb_rsp_stage.sv
// Response register for one fetch port: one cycle from acceptance to response.
// Assumes: fire_i is high only in cycles where the port accepted a request.
module ibb_rsp_stage #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o
);
    // Register the response; the word holds while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            word_o  <= '0;
        end else begin
            valid_o <= fire_i;
            if (fire_i) word_o <= word_i;
        end
    end
endmodule

// File: rtl/istream_bind_buf.sv
// Instruction stream binding buffer top. It resolves two fetch ports against
// the binding table in one cycle. Unbound addresses are bound in first-fetch
// order, port 0 before port 1. A shared new address takes one word. When no
// slot is free, the fill word is returned and the sticky overflow flag is set.
// Assumes: requesters hold nothing across a load; readies drop only while loading.
module istream_bind_buf #(
    parameter int          ADDR_W      = 32,
    parameter int          WORD_W      = 32,
    parameter int          NUM_ENTRIES = 5,
    parameter int          DEPTH       = 64,
    parameter logic [31:0] NOP_WORD    = ibb_pkg::IBB_NOP_WORD
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [NUM_ENTRIES*WORD_W-1:0] vector_i,
    input  logic                          p0_req_valid,
    output logic                          p0_req_ready,
    input  logic [ADDR_W-1:0]             p0_req_addr,
    output logic                          p0_rsp_valid,
    output logic [WORD_W-1:0]             p0_rsp_word,
    input  logic                          p1_req_valid,
    output logic                          p1_req_ready,
    input  logic [ADDR_W-1:0]             p1_req_addr,
    output logic                          p1_rsp_valid,
    output logic [WORD_W-1:0]             p1_rsp_word,
    output logic                          overflow_o
);
    import ibb_pkg::*;

    localparam int NUM_PORTS = 2;
    localparam int CNT_W     = $clog2(DEPTH + 1);

    logic              acc0, acc1;
    logic              hit0, hit1;
    logic [WORD_W-1:0] hword0, hword1;
    logic              miss0, miss1_raw, miss1, shared;
    logic              grant0, grant1;
    logic [CNT_W-1:0]  used;
    logic [CNT_W-1:0]  room;
    logic [WORD_W-1:0] word_a, word_b;
    logic [1:0]        adv;
    ibb_src_e          src0, src1;
    logic              ovf_set;
    logic              ovf_q;
    logic              wr_a_en, wr_b_en;
    logic [ADDR_W-1:0] wr_a_addr;
    logic [WORD_W-1:0] wr_a_word;

    logic              fire   [NUM_PORTS];
    logic [WORD_W-1:0] resw   [NUM_PORTS];
    logic              rsp_v  [NUM_PORTS];
    logic [WORD_W-1:0] rsp_w  [NUM_PORTS];

    // Requests are accepted whenever no load is in progress.
    always_comb begin
        p0_req_ready = !load_i;
        p1_req_ready = !load_i;
        acc0         = p0_req_valid && p0_req_ready;
        acc1         = p1_req_valid && p1_req_ready;
    end

    ibb_bind_table #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (load_i),
        .look0_addr_i (p0_req_addr),
        .look0_hit_o  (hit0),
        .look0_word_o (hword0),
        .look1_addr_i (p1_req_addr),
        .look1_hit_o  (hit1),
        .look1_word_o (hword1),
        .wr_a_en_i    (wr_a_en),
        .wr_a_addr_i  (wr_a_addr),
        .wr_a_word_i  (wr_a_word),
        .wr_b_en_i    (wr_b_en),
        .wr_b_addr_i  (p1_req_addr),
        .wr_b_word_i  (word_b),
        .used_o       (used)
    );

    ibb_entry_alloc #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .WORD_W      (WORD_W)
    ) u_alloc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .vector_i (vector_i),
        .adv_i    (adv),
        .word_a_o (word_a),
        .word_b_o (word_b)
    );

    // Classify misses and grant free slots, port 0 first.
    always_comb begin
        miss0     = acc0 && !hit0;
        miss1_raw = acc1 && !hit1;
        shared    = miss0 && miss1_raw && (p0_req_addr == p1_req_addr);
        miss1     = miss1_raw && !shared;
        room      = CNT_W'(DEPTH) - used;
        grant0    = miss0 && (room != '0);
        grant1    = miss1 && (room > CNT_W'(grant0));
        ovf_set   = (miss0 && !grant0) || (miss1 && !grant1);
        adv       = 2'(grant0) + 2'(grant1);
    end

    // Pick the source of each port's word.
    always_comb begin
        if (!acc0)       src0 = SRC_IDLE;
        else if (hit0)   src0 = SRC_HIT;
        else if (grant0) src0 = SRC_FRESH_A;
        else             src0 = SRC_FILL;

        if (!acc1)       src1 = SRC_IDLE;
        else if (hit1)   src1 = SRC_HIT;
        else if (shared) src1 = SRC_SHARED;
        else if (grant1) src1 = grant0 ? SRC_FRESH_B : SRC_FRESH_A;
        else             src1 = SRC_FILL;
    end

    // Form the response word of each port from its source.
    always_comb begin
        case (src0)
            SRC_HIT:     resw[0] = hword0;
            SRC_FRESH_A: resw[0] = word_a;
            SRC_FILL:    resw[0] = WORD_W'(NOP_WORD);
            default:     resw[0] = '0;
        endcase
        case (src1)
            SRC_HIT:     resw[1] = hword1;
            SRC_SHARED:  resw[1] = resw[0];
            SRC_FRESH_A: resw[1] = word_a;
            SRC_FRESH_B: resw[1] = word_b;
            SRC_FILL:    resw[1] = WORD_W'(NOP_WORD);
            default:     resw[1] = '0;
        endcase
        fire[0] = acc0;
        fire[1] = acc1;
    end

    // Record new bindings: the first grant goes to slot A, a second to slot B.
    always_comb begin
        wr_a_en   = grant0 || grant1;
        wr_a_addr = grant0 ? p0_req_addr : p1_req_addr;
        wr_a_word = word_a;
        wr_b_en   = grant0 && grant1;
    end

    // Sticky overflow flag, cleared by reset or load.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) ovf_q <= 1'b0;
        else if (ovf_set)     ovf_q <= 1'b1;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ibb_rsp_stage #(
            .WORD_W (WORD_W)
        ) u_rsp (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire_i  (fire[p]),
            .word_i  (resw[p]),
            .valid_o (rsp_v[p]),
            .word_o  (rsp_w[p])
        );
    end

    assign p0_rsp_valid = rsp_v[0];
    assign p0_rsp_word  = rsp_w[0];
    assign p1_rsp_valid = rsp_v[1];
    assign p1_rsp_word  = rsp_w[1];
    assign overflow_o   = ovf_q;
endmodule

// File: rtl/ibb_checker.sv
// Property checker for the binding buffer, attached through bind.
// Assumes: it sees only the top-level ports.
module ibb_checker #(
    parameter int          ADDR_W   = 32,
    parameter int          WORD_W   = 32,
    parameter logic [31:0] NOP_WORD = 32'h0000_0013
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              p0_req_valid,
    input logic              p0_req_ready,
    input logic [ADDR_W-1:0] p0_req_addr,
    input logic              p0_rsp_valid,
    input logic [WORD_W-1:0] p0_rsp_word,
    input logic              p1_req_valid,
    input logic              p1_req_ready,
    input logic [ADDR_W-1:0] p1_req_addr,
    input logic              p1_rsp_valid,
    input logic [WORD_W-1:0] p1_rsp_word,
    input logic              overflow_o
);
    a_r8_p0_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req_valid && p0_req_ready) |=> p0_rsp_valid);
    a_r8_p1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_req_valid && p1_req_ready) |=> p1_rsp_valid);
    a_r8_p0_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(p0_req_valid && p0_req_ready) |=> !p0_rsp_valid);
    a_r8_p1_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(p1_req_valid && p1_req_ready) |=> !p1_rsp_valid);
    a_r6_same_addr_same_word: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req_valid && p0_req_ready && p1_req_valid && p1_req_ready
         && p0_req_addr == p1_req_addr) |=> (p0_rsp_word == p1_rsp_word));
    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !load_i) |=> overflow_o);
    a_r9_overflow_with_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> ((p0_rsp_valid && p0_rsp_word == WORD_W'(NOP_WORD))
                            || (p1_rsp_valid && p1_rsp_word == WORD_W'(NOP_WORD))));
    a_r10_not_ready_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (!p0_req_ready && !p1_req_ready));
    a_r10_load_clears_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !overflow_o);
endmodule

bind istream_bind_buf ibb_checker #(
    .ADDR_W   (ADDR_W),
    .WORD_W   (WORD_W),
    .NOP_WORD (NOP_WORD)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .p0_req_valid (p0_req_valid),
    .p0_req_ready (p0_req_ready),
    .p0_req_addr  (p0_req_addr),
    .p0_rsp_valid (p0_rsp_valid),
    .p0_rsp_word  (p0_rsp_word),
    .p1_req_valid (p1_req_valid),
    .p1_req_ready (p1_req_ready),
    .p1_req_addr  (p1_req_addr),
    .p1_rsp_valid (p1_rsp_valid),
    .p1_rsp_word  (p1_rsp_word),
    .overflow_o   (overflow_o)
);

// File: tb/sim_istream_bind_buf.sv
// Scoreboard bench: the driver computes expected words from a requirement
// model and queues them; the monitor compares each response as it appears.
module sim_istream_bind_buf;
    localparam int          NE    = 5;
    localparam int          DEP   = 64;
    localparam logic [31:0] NOP_W = 32'h0000_0013;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_i = 1'b0;
    logic [NE*32-1:0] vector_i = '0;
    logic p0_req_valid = 1'b0, p1_req_valid = 1'b0;
    logic [31:0] p0_req_addr = '0, p1_req_addr = '0;
    logic p0_req_ready, p1_req_ready, p0_rsp_valid, p1_rsp_valid, overflow_o;
    logic [31:0] p0_rsp_word, p1_rsp_word;

    always #10 clk = ~clk;  // 50 MHz

    istream_bind_buf u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .vector_i(vector_i),
        .p0_req_valid(p0_req_valid), .p0_req_ready(p0_req_ready),
        .p0_req_addr(p0_req_addr), .p0_rsp_valid(p0_rsp_valid),
        .p0_rsp_word(p0_rsp_word),
        .p1_req_valid(p1_req_valid), .p1_req_ready(p1_req_ready),
        .p1_req_addr(p1_req_addr), .p1_rsp_valid(p1_rsp_valid),
        .p1_rsp_word(p1_rsp_word), .overflow_o(overflow_o)
    );

    typedef struct {
        logic [31:0] w;
        bit          ovf;
        string       tag;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];
    int   n_chk = 0;
    int   n_bad = 0;

    // Requirement model state.
    logic [31:0] m_tbl [logic [31:0]];
    logic [31:0] m_ent [NE];
    int          m_idx = 0;
    int          m_cnt = 0;
    bit          m_ovf = 1'b0;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_fetch(logic [31:0] a, output logic [31:0] w);
        if (m_tbl.exists(a)) w = m_tbl[a];
        else if (m_cnt < DEP) begin
            w = m_ent[m_idx];
            m_tbl[a] = w;
            m_idx = (m_idx + 1) % NE;
            m_cnt++;
        end else begin
            w = NOP_W;
            m_ovf = 1'b1;
        end
    endtask

    // Driver: present one cycle of requests and queue the expected responses.
    task automatic issue(bit v0, logic [31:0] a0, bit v1, logic [31:0] a1, string tag);
        logic [31:0] e0, e1;
        @(negedge clk);
        p0_req_valid = v0; p0_req_addr = a0;
        p1_req_valid = v1; p1_req_addr = a1;
        e0 = '0; e1 = '0;
        if (v0) model_fetch(a0, e0);
        if (v1) model_fetch(a1, e1);
        if (v0) q0.push_back('{e0, m_ovf, tag});
        if (v1) q1.push_back('{e1, m_ovf, tag});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            p0_req_valid = 1'b0;
            p1_req_valid = 1'b0;
        end
    endtask

    task automatic load_vec(logic [31:0] base);
        @(negedge clk);
        p0_req_valid = 1'b0;
        p1_req_valid = 1'b0;
        for (int k = 0; k < NE; k++) begin
            vector_i[k*32 +: 32] = base + 32'(k);
            m_ent[k] = base + 32'(k);
        end
        load_i = 1'b1;
        #1;
        check(!p0_req_ready && !p1_req_ready, "R10 ready low in load",
              {30'b0, p0_req_ready, p1_req_ready}, 32'h0);
        m_tbl.delete();
        m_idx = 0; m_cnt = 0; m_ovf = 1'b0;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    // Monitor: compare responses away from the clock edge.
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #5;
            if (rst_n) begin
                if (p0_rsp_valid) begin
                    if (q0.size() == 0) check(1'b0, "R8 stray p0 rsp", 32'h1, 32'h0);
                    else begin
                        it = q0.pop_front();
                        check(p0_rsp_word == it.w, {it.tag, " p0"}, p0_rsp_word, it.w);
                        check(overflow_o == it.ovf, "R9 overflow p0", 32'(overflow_o), 32'(it.ovf));
                    end
                end
                if (p1_rsp_valid) begin
                    if (q1.size() == 0) check(1'b0, "R8 stray p1 rsp", 32'h1, 32'h0);
                    else begin
                        it = q1.pop_front();
                        check(p1_rsp_word == it.w, {it.tag, " p1"}, p1_rsp_word, it.w);
                        check(overflow_o == it.ovf, "R9 overflow p1", 32'(overflow_o), 32'(it.ovf));
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        rst_n = 1'b1;
        @(posedge clk); #5;
        check(!p0_rsp_valid && !p1_rsp_valid, "R1 rsp valid low",
              {30'b0, p0_rsp_valid, p1_rsp_valid}, 32'h0);
        check(!overflow_o, "R1 overflow low", 32'(overflow_o), 32'h0);
        check(p0_req_ready && p1_req_ready, "R1 ready high",
              {30'b0, p0_req_ready, p1_req_ready}, 32'h3);

        load_vec(32'hA500_0100);
        issue(1, 32'h100, 0, 0, "R2 first word");
        issue(1, 32'h104, 0, 0, "R2 second word");
        issue(1, 32'h108, 0, 0, "R2 third word");
        issue(0, 0, 1, 32'h104, "R5 cross port");
        issue(1, 32'h100, 0, 0, "R3 refetch");
        issue(0, 0, 1, 32'h200, "R2 p1 new");
        issue(0, 0, 1, 32'h204, "R2 p1 new last");
        issue(1, 32'h300, 0, 0, "R4 wrap to word 0");
        issue(1, 32'h400, 1, 32'h400, "R6 shared new");
        issue(1, 32'h404, 0, 0, "R6 following word");
        issue(1, 32'h500, 1, 32'h504, "R7 port order");
        issue(1, 32'h504, 1, 32'h500, "R3 R5 swapped refetch");
        idle(2);
        check(!p0_rsp_valid && !p1_rsp_valid, "R8 idle no rsp",
              {30'b0, p0_rsp_valid, p1_rsp_valid}, 32'h0);

        load_vec(32'h5B00_0010);
        issue(1, 32'h500, 1, 32'h100, "R10 rebind after load");

        load_vec(32'h7C00_0000);
        for (int i = 0; i < DEP - 1; i++) issue(1, 32'h1000 + 32'(4*i), 0, 0, "R2 fill");
        issue(1, 32'h2000, 1, 32'h2004, "R9 last slot split");
        issue(1, 32'h2008, 0, 0, "R9 fill word");
        issue(0, 0, 1, 32'h1000, "R9 hit when full");
        issue(1, 32'h2000, 0, 0, "R9 last bound hits");
        idle(2);
        check(overflow_o, "R9 sticky overflow", 32'(overflow_o), 32'h1);
        load_vec(32'h0D00_0000);
        @(posedge clk); #5;
        check(!overflow_o, "R10 overflow cleared", 32'(overflow_o), 32'h0);
        issue(1, 32'h2008, 0, 0, "R10 fresh start word 0");
        idle(3);
        check(q0.size() == 0 && q1.size() == 0, "R8 all responses seen",
              32'(q0.size() + q1.size()), 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule